// File: doc/BRIEF.md
# Pushbutton Reset Qualifier

This block cleans up an active-low reset request that comes from a mechanical pushbutton or from external logic. The raw level is brought into the clock domain through a flop chain. It is then judged against a slow time base of one tick per millisecond. A low level has to last for a set number of ticks before the block accepts it as a real press. Any high sample seen before that point throws away the partial count, so short glitches and contact chatter never reach the reset generator downstream.

Once a press is accepted, the qualified output stays active for as long as the input stays low. After the input goes high, the output stays active until the input has been high for a further set number of ticks. Bounce on release therefore cannot chop the request into pieces, and the reset that follows always extends past the moment the button is let go. With the default settings (four ticks to accept, two ticks to release), a low pulse shorter than one tick is always rejected. A low level held for 20 ms is always accepted, and the typical delay from press to acceptance is about 4 ms.

Top module: `pb_reset_qualifier`

## Requirements
- R1: After reset, and for as long as the raw input stays high, the qualified press output `press_o` is 0.
- R2: A low pulse on `btn_n_i` that is shorter than one tick period (`CLKS_PER_TICK` clocks) never makes `press_o` go to 1.
- R3: A low level held for `PRESS_TICKS * CLKS_PER_TICK + 4` clocks or longer always makes `press_o` go to 1, no later than that many clocks after the input fell.
- R4: `press_o` never goes to 1 earlier than `(PRESS_TICKS - 1) * CLKS_PER_TICK` clocks after the input fell.
- R5: A single high sample during the acceptance count clears the count. Two low stretches of 2.5 tick periods each, separated by one high clock, give no press.
- R6: Once `press_o` is 1, it stays 1 for as long as the input stays low.
- R7: After the input returns high, `press_o` stays 1 for at least `(RELEASE_TICKS - 1) * CLKS_PER_TICK` clocks and is 0 no later than `RELEASE_TICKS * CLKS_PER_TICK + 4` clocks after the rise.
- R8: During a press, a high bounce shorter than one tick period does not clear `press_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n_i | input | 1 | Raw asynchronous reset request, active low |
| press_o | output | 1 | Qualified press level, active high |

## Verification
The bench builds the block with a 20-clock tick, four ticks to accept and two ticks to release. This keeps every tick boundary, every acceptance window and every release window within a few hundred clocks, so pulse lengths across the whole range can be exercised. That range runs from below one tick, through the window where the outcome may go either way, to well past the guaranteed threshold. Pulse lengths are drawn at random, so the press edge falls at many different tick phases. Directed cases cover the restart on a single high clock and bounce during a held press.

// File: rtl/pbq_pkg.sv
// Package: shared types and helpers for the pushbutton reset qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package pbq_pkg;

    // Qualifier states: idle, counting a low level, press held, counting a release.
    typedef enum logic [1:0] {
        QS_IDLE = 2'd0,
        QS_ARM  = 2'd1,
        QS_HELD = 2'd2,
        QS_REL  = 2'd3
    } qual_state_t;

    // Larger of two integers, used to size shared counters.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbq_sync.sv
// Module: pbq_sync
// Brings the raw active-low button level into the clock domain through a
// flop chain. It presents the result as an active-high "low seen" level.
// Assumes: STAGES >= 2; the chain resets to the idle (high) level.
module pbq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n_i,
    output logic low_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_n_i};
        end
    end

    assign low_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/pbq_tick.sv
// Module: pbq_tick
// Free-running divider that gives a one-clock pulse every CLKS_PER_TICK
// clocks. This is the millisecond time base for qualification.
// Assumes: CLKS_PER_TICK >= 1.
module pbq_tick #(
    parameter int CLKS_PER_TICK = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (CLKS_PER_TICK == 1) begin : g_every
            // Degenerate divider: every clock is a tick.
            assign tick_o = rst_n;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

            logic [CW-1:0] div_q;
            logic          tick_q;

            // Count clocks and fire one pulse when the period completes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q  <= '0;
                    tick_q <= 1'b0;
                end else if (div_q == LAST) begin
                    div_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    div_q  <= div_q + 1'b1;
                    tick_q <= 1'b0;
                end
            end

            assign tick_o = tick_q;

            // Ticks are isolated pulses, spaced by the period (R3 time base).
            assert_tick_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate

endmodule

// File: rtl/pbq_qualifier.sv
// Module: pbq_qualifier
// Decides when a synchronised low level counts as a real press and when the
// press has ended. A press is accepted after PRESS_TICKS ticks of unbroken
// low. It is released after RELEASE_TICKS ticks of unbroken high.
// Assumes: low_i is already synchronous; tick_i is a one-clock pulse;
// PRESS_TICKS >= 2 so that a pulse shorter than one tick cannot qualify.
module pbq_qualifier
    import pbq_pkg::*;
#(
    parameter int PRESS_TICKS   = 4,
    parameter int RELEASE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic tick_i,
    output logic press_o
);

    localparam int              MAXT         = max_of(PRESS_TICKS, RELEASE_TICKS);
    localparam int              CW           = $clog2(MAXT + 1);
    localparam logic [CW-1:0]   PRESS_LAST   = CW'(PRESS_TICKS - 1);
    localparam logic [CW-1:0]   RELEASE_LAST = CW'(RELEASE_TICKS - 1);

    qual_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state and counter rules for acceptance and release.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            QS_IDLE: begin
                if (low_i) begin
                    state_d = QS_ARM;
                    cnt_d   = '0;
                end
            end
            QS_ARM: begin
                if (!low_i) begin
                    state_d = QS_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == PRESS_LAST) begin
                        state_d = QS_HELD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            QS_HELD: begin
                if (!low_i) begin
                    state_d = QS_REL;
                    cnt_d   = '0;
                end
            end
            QS_REL: begin
                if (low_i) begin
                    state_d = QS_HELD;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == RELEASE_LAST) begin
                        state_d = QS_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = QS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign press_o = (state_q == QS_HELD) || (state_q == QS_REL);

    // A press can only begin on a tick seen while the input was low.
    assert_rise_on_low_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(press_o) |-> $past(low_i && tick_i));

    // A press can only end on a tick seen while the input was high.
    assert_fall_on_high_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(press_o) |-> $past(!low_i && tick_i));

    // While the press is active and the input is low, it stays active.
    assert_hold_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (press_o && low_i) |=> press_o);

    // A high sample while arming always drops back to idle (count restart).
    assert_restart_on_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_ARM && !low_i) |=> (state_q == QS_IDLE));

    // Counter never runs past its largest threshold.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXT));

    // With the input high and idle, no press can appear (R1).
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_IDLE && !low_i) |=> !press_o);

endmodule

// File: rtl/pb_reset_qualifier.sv
// Module: pb_reset_qualifier
// Top of the pushbutton reset qualifier: synchroniser, millisecond tick and
// press/release qualifier. The output is a clean active-high press level.
// Assumes: CLKS_PER_TICK clocks make one millisecond; PRESS_TICKS >= 2.
module pb_reset_qualifier #(
    parameter int CLKS_PER_TICK = 125000,
    parameter int PRESS_TICKS   = 4,
    parameter int RELEASE_TICKS = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_i,
    output logic press_o
);

    logic low_s;
    logic tick_s;

    pbq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_n_i (btn_n_i),
        .low_o   (low_s)
    );

    pbq_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_s)
    );

    pbq_qualifier #(
        .PRESS_TICKS   (PRESS_TICKS),
        .RELEASE_TICKS (RELEASE_TICKS)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (low_s),
        .tick_i  (tick_s),
        .press_o (press_o)
    );

endmodule

// File: tb/pb_reset_qualifier_tb_top.sv
module pb_reset_qualifier_tb_top;

    localparam int T    = 20;
    localparam int NP   = 4;
    localparam int NR   = 2;
    localparam int SLK  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic press;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pb_reset_qualifier #(
        .CLKS_PER_TICK (T),
        .PRESS_TICKS   (NP),
        .RELEASE_TICKS (NR),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n_i (btn_n),
        .press_o (press)
    );

    // 0: must not press, 1: must press, 2: either.
    function automatic int classify(input int len);
        if (len < T) return 0;
        if (len >= NP * T + SLK) return 1;
        return 2;
    endfunction

    function automatic int rise_min();
        return (NP - 1) * T;
    endfunction

    function automatic int rise_max();
        return NP * T + SLK;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Low pulse of len clocks, then a release window; checks R2/R3/R4/R6/R7.
    task automatic pulse(input int len);
        int  rise_at = -1;
        bit  seen = 0;
        bit  hold_ok = 1;
        bit  rel_ok = 1;
        int  cls = classify(len);
        btn_n = 1'b0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (press) begin
                seen = 1;
                if (rise_at < 0) rise_at = i;
            end else if (rise_at >= 0) begin
                hold_ok = 0;
            end
        end
        btn_n = 1'b1;
        for (int i = 1; i <= NR * T + SLK + 4; i++) begin
            @(negedge clk);
            if (press) seen = 1;
            if (rise_at >= 0 && i <= (NR - 1) * T && !press) rel_ok = 0;
        end
        if (cls == 0) chk(!seen, "R2 short pulse rejected", int'(seen), 0);
        if (cls == 1) chk(rise_at >= 0 && rise_at <= rise_max(),
                          "R3 long pulse accepted in time", rise_at, rise_max());
        if (rise_at >= 0) begin
            chk(rise_at >= rise_min(), "R4 minimum acceptance delay", rise_at, rise_min());
            chk(hold_ok, "R6 press held while low", int'(hold_ok), 1);
            chk(rel_ok, "R7 press held after release", int'(rel_ok), 1);
        end
        chk(press == 1'b0, "R7 press cleared after release window", int'(press), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(press == 1'b0, "R1 press low in reset", int'(press), 0);
        rst_n = 1'b1;

        // R1: constant high input stays idle.
        ok = 1;
        for (int i = 0; i < 10 * T; i++) begin
            @(negedge clk);
            if (press) ok = 0;
        end
        chk(ok, "R1 idle with input high", int'(ok), 1);

        // R2 boundary: one clock short of a tick.
        pulse(T - 1);
        pulse(1);
        // R3 boundary: exactly the guaranteed length, and a long hold.
        pulse(NP * T + SLK);
        pulse(20 * T);

        // R5: two 2.5-tick lows split by a single high clock.
        ok = 1;
        btn_n = 1'b0;
        for (int i = 0; i < (5 * T) / 2; i++) begin
            @(negedge clk);
            if (press) ok = 0;
        end
        btn_n = 1'b1;
        @(negedge clk);
        if (press) ok = 0;
        btn_n = 1'b0;
        for (int i = 0; i < (5 * T) / 2; i++) begin
            @(negedge clk);
            if (press) ok = 0;
        end
        btn_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (press) ok = 0;
        end
        chk(ok, "R5 count restarts on high sample", int'(ok), 1);
        repeat (3 * T) @(negedge clk);

        // R8: short high bounce while pressed.
        btn_n = 1'b0;
        repeat (NP * T + SLK + 2) @(negedge clk);
        chk(press == 1'b1, "R8 press established", int'(press), 1);
        ok = 1;
        btn_n = 1'b1;
        for (int i = 0; i < T - 1; i++) begin
            @(negedge clk);
            if (!press) ok = 0;
        end
        btn_n = 1'b0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (!press) ok = 0;
        end
        chk(ok, "R8 bounce does not clear press", int'(ok), 1);
        btn_n = 1'b1;
        repeat (NR * T + SLK + 4) @(negedge clk);
        chk(press == 1'b0, "R7 release after bounce test", int'(press), 0);

        // Random pulse lengths over the whole range.
        for (int k = 0; k < 40; k++) begin
            int len = 1 + $urandom_range(2 * NP * T);
            pulse(len);
            repeat ($urandom_range(T)) @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule